// File: doc/BRIEF.md
# Power-On Reset Exception Sequencer

This block sits between the external active-low reset pin and the processor core. It filters the pin so that only a low level held for a minimum number of running clock cycles counts as a reset, and shorter glitches are dropped. When a qualified reset is released, the block fetches two vector words through a simple read port: first the initial program counter and then the initial stack pointer. It then loads both words into the core's architectural registers, together with fixed reset values for the vector base, the status-register interrupt mask and flag bits, and the floating-point status/control word. Only after that does it raise a run enable that lets instruction fetch begin.

The block also takes reset requests from a watchdog overflow and from a debug command. These are manual resets. They repeat the vector fetch and the register initialisation, but they leave on-chip peripherals and the interrupt controller's bank bit alone. A `reset_kind` output tells the core which kind of reset ran most recently. The peripheral reset strobe and the bank-bit clear strobe fire only for a power-on reset.

Top module: `rstseq_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `run_en`, `mem_req_valid`, `periph_rst`, `arch_load` and `bn_clr` are 0, and `reset_kind` is 0.
- R2: A low level on `ext_rst_n` qualifies as a reset once it has been sampled low for QUAL_CYCLES (default 20) consecutive clocks. A low pulse of QUAL_CYCLES-1 clocks has no effect on `run_en` and issues no memory read.
- R3: After qualification, no vector read is issued and `run_en` stays 0 for as long as `ext_rst_n` remains low. The sequence starts only after `ext_rst_n` returns high.
- R4: The sequence reads byte address VEC_BASE (default 0x00000000) first and VEC_BASE+4 second. A read is accepted on a cycle where `mem_req_valid` and `mem_req_ready` are both 1, and its data is taken from the first later cycle with `mem_rsp_valid` high. Address and valid are held while the read is not yet accepted.
- R5: In the cycle after `arch_load`, `pc_value` equals the word read from VEC_BASE and `sp_value` equals the word read from VEC_BASE+4.
- R6: In the cycle after `arch_load`, `vbr_value` is 0x00000000, `sr_imask` is 4'b1111, `sr_bo` and `sr_cs` are 0, and `fpscr_value` is 0x00040001.
- R7: `run_en` rises only in the cycle directly after a one-cycle `arch_load` pulse.
- R8: A power-on sequence sets `reset_kind` to 0, pulses `periph_rst` once for one cycle, and pulses `bn_clr` together with `arch_load`.
- R9: While `run_en` is 1, a one-cycle pulse on `wdt_ovf` or `dbg_mreset` drops `run_en` in the next cycle and runs the vector fetch and load again with `reset_kind` = 1. No `periph_rst` or `bn_clr` pulse occurs.
- R10: `wdt_ovf` and `dbg_mreset` are ignored while `run_en` is 0. After reset with no qualified pin reset, they issue no read. During a pin reset, the following sequence still reports `reset_kind` = 0.
- R11: A qualified pin reset in any state, including while a vector read is stalled, forces `run_en` to 0 and withdraws `mem_req_valid`. The whole power-on sequence then restarts when the pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| ext_rst_n | input | 1 | External active-low reset pin, asynchronous |
| wdt_ovf | input | 1 | Watchdog overflow request (manual reset) |
| dbg_mreset | input | 1 | Debug manual-reset command |
| mem_req_valid | output | 1 | Vector read request valid |
| mem_req_addr | output | ADDR_W | Vector read byte address |
| mem_req_ready | input | 1 | Read request accepted |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| run_en | output | 1 | Core may fetch instructions |
| reset_kind | output | 1 | 0 = power-on, 1 = manual |
| periph_rst | output | 1 | One-cycle peripheral reset strobe |
| bn_clr | output | 1 | Clear the interrupt bank number bit |
| arch_load | output | 1 | Architectural registers written this cycle |
| pc_value | output | 32 | Program counter initial value |
| sp_value | output | 32 | Stack pointer initial value |
| vbr_value | output | 32 | Vector base register value |
| sr_imask | output | 4 | Status-register interrupt mask |
| sr_bo | output | 1 | Status-register BO flag |
| sr_cs | output | 1 | Status-register CS flag |
| fpscr_value | output | 32 | Floating-point status/control value |

## Verification
The hardest situation to reach is a pin reset that qualifies while a vector read is stalled between request and acceptance. The fetch engine must drop the read, and a late ready or stray response must not leak into the restarted sequence. The bench's read responder has a programmable ready delay. A test starts a manual reset with a long stall and then holds the pin low across the stall. The qualification threshold is probed with pulses of exactly QUAL_CYCLES and QUAL_CYCLES-1 clocks, driven on falling edges so the synchroniser lag cancels out.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE_RESET = 3'd0,
        ST_QUALIFY    = 3'd1,
        ST_FETCH_PC   = 3'd2,
        ST_FETCH_SP   = 3'd3,
        ST_INIT_REGS  = 3'd4,
        ST_RUN        = 3'd5
    } seq_state_e;

    typedef enum logic {
        KIND_POWER_ON = 1'b0,
        KIND_MANUAL   = 1'b1
    } rst_kind_e;

    typedef enum logic [1:0] {
        FT_IDLE = 2'd0,
        FT_REQ  = 2'd1,
        FT_WAIT = 2'd2
    } fetch_state_e;

    localparam logic [WORD_W-1:0] VBR_RESET   = 32'h0000_0000;
    localparam logic [3:0]        IMASK_RESET = 4'hF;
    localparam logic [WORD_W-1:0] FPSCR_RESET = 32'h0004_0001;

    typedef struct packed {
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] sp;
        logic [WORD_W-1:0] vbr;
        logic [3:0]        imask;
        logic              bo;
        logic              cs;
        logic [WORD_W-1:0] fpscr;
    } arch_init_t;

    function automatic arch_init_t build_arch_init(
        input logic [WORD_W-1:0] pc_word,
        input logic [WORD_W-1:0] sp_word
    );
        arch_init_t r;
        r.pc    = pc_word;
        r.sp    = sp_word;
        r.vbr   = VBR_RESET;
        r.imask = IMASK_RESET;
        r.bo    = 1'b0;
        r.cs    = 1'b0;
        r.fpscr = FPSCR_RESET;
        return r;
    endfunction

endpackage

// File: rtl/rstseq_qualifier.sv
module rstseq_qualifier #(
    parameter int unsigned QUAL_CYCLES = 20,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_rst_n,
    output logic pin_high,
    output logic qual_hit
);
    localparam int unsigned CNT_W = $clog2(QUAL_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUAL_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(QUAL_CYCLES);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       low_cnt;
    logic                   pin_low;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], ext_rst_n};
    end

    assign pin_low  = ~sync_q[SYNC_STAGES-1];
    assign pin_high = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst || !pin_low)      low_cnt <= '0;
        else if (low_cnt != CNT_SAT) low_cnt <= low_cnt + CNT_W'(1);
    end

    assign qual_hit = pin_low && (low_cnt == CNT_LAST);

    AST_HIT_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
        qual_hit |-> $past(pin_low)) else $error("hit without prior low");  // R2
    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (rst)
        qual_hit |=> !qual_hit) else $error("double qualification");  // R2
endmodule

// File: rtl/rstseq_vec_fetch.sv
module rstseq_vec_fetch
    import rstseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              abort,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [WORD_W-1:0] rsp_data,
    output logic              done,
    output logic [WORD_W-1:0] data
);
    fetch_state_e      st;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= FT_IDLE;
            addr_q <= '0;
        end else if (abort) begin
            st <= FT_IDLE;
        end else begin
            case (st)
                FT_IDLE: if (start) begin
                    st     <= FT_REQ;
                    addr_q <= start_addr;
                end
                FT_REQ:  if (req_ready) st <= FT_WAIT;
                FT_WAIT: if (rsp_valid) st <= FT_IDLE;
                default: st <= FT_IDLE;
            endcase
        end
    end

    assign req_valid = (st == FT_REQ);
    assign req_addr  = addr_q;
    assign done      = (st == FT_WAIT) && rsp_valid && !abort;
    assign data      = rsp_data;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !abort) |=> (req_valid && $stable(req_addr)))
        else $error("request dropped before acceptance");  // R4
    AST_ABORT_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
        abort |=> !req_valid) else $error("request survives abort");  // R11
endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              qual_hit,
    input  logic              pin_high,
    input  logic              manual_req,
    input  logic              fetch_done,
    input  logic [WORD_W-1:0] fetch_data,
    output logic              fetch_start,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_abort,
    output logic [WORD_W-1:0] pc_word,
    output logic [WORD_W-1:0] sp_word,
    output logic              arch_load,
    output logic              run_en,
    output rst_kind_e         kind,
    output logic              periph_rst,
    output logic              bn_clr
);
    localparam logic [ADDR_W-1:0] PC_VEC_ADDR = VEC_BASE;
    localparam logic [ADDR_W-1:0] SP_VEC_ADDR = VEC_BASE + ADDR_W'(4);

    seq_state_e state, nxt;
    logic       issued;
    logic       in_fetch;

    assign in_fetch    = (state == ST_FETCH_PC) || (state == ST_FETCH_SP);
    assign fetch_start = in_fetch && !issued && !qual_hit;
    assign fetch_addr  = (state == ST_FETCH_SP) ? SP_VEC_ADDR : PC_VEC_ADDR;
    assign fetch_abort = qual_hit;

    always_comb begin
        nxt = state;
        if (qual_hit) begin
            nxt = ST_QUALIFY;
        end else begin
            case (state)
                ST_IDLE_RESET: nxt = ST_IDLE_RESET;
                ST_QUALIFY:    if (pin_high) nxt = ST_FETCH_PC;
                ST_FETCH_PC:   if (fetch_done) nxt = ST_FETCH_SP;
                ST_FETCH_SP:   if (fetch_done) nxt = ST_INIT_REGS;
                ST_INIT_REGS:  nxt = ST_RUN;
                ST_RUN:        if (manual_req) nxt = ST_FETCH_PC;
                default:       nxt = ST_IDLE_RESET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE_RESET;
            issued     <= 1'b0;
            kind       <= KIND_POWER_ON;
            periph_rst <= 1'b0;
            pc_word    <= '0;
            sp_word    <= '0;
        end else begin
            state      <= nxt;
            periph_rst <= 1'b0;
            if (qual_hit) begin
                issued <= 1'b0;
            end else begin
                case (state)
                    ST_QUALIFY: if (pin_high) begin
                        kind       <= KIND_POWER_ON;
                        periph_rst <= 1'b1;
                        issued     <= 1'b0;
                    end
                    ST_FETCH_PC: begin
                        if (fetch_start) issued <= 1'b1;
                        if (fetch_done) begin
                            pc_word <= fetch_data;
                            issued  <= 1'b0;
                        end
                    end
                    ST_FETCH_SP: begin
                        if (fetch_start) issued <= 1'b1;
                        if (fetch_done) begin
                            sp_word <= fetch_data;
                            issued  <= 1'b0;
                        end
                    end
                    ST_RUN: if (manual_req) begin
                        kind   <= KIND_MANUAL;
                        issued <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign arch_load = (state == ST_INIT_REGS);
    assign run_en    = (state == ST_RUN);
    assign bn_clr    = arch_load && (kind == KIND_POWER_ON);

    AST_RUN_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(run_en) |-> $past(arch_load)) else $error("run before load");  // R7
    AST_PERIPH_POWER_ON: assert property (@(posedge clk) disable iff (rst)
        periph_rst |-> (kind == KIND_POWER_ON)) else $error("periph reset on manual");  // R8
    AST_QUAL_STOPS_RUN: assert property (@(posedge clk) disable iff (rst)
        qual_hit |=> (!run_en && !fetch_start)) else $error("qualified reset ignored");  // R11
    AST_MANUAL_DROPS_RUN: assert property (@(posedge clk) disable iff (rst)
        (run_en && manual_req) |=> !run_en) else $error("manual reset ignored in run");  // R9
    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        arch_load |=> !arch_load) else $error("load longer than one cycle");  // R7
endmodule

// File: rtl/rstseq_arch_regs.sv
module rstseq_arch_regs
    import rstseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] pc_word,
    input  logic [WORD_W-1:0] sp_word,
    output arch_init_t        regs
);
    always_ff @(posedge clk) begin
        if (rst)       regs <= '0;
        else if (load) regs <= build_arch_init(pc_word, sp_word);
    end

    AST_INIT_VALUES: assert property (@(posedge clk) disable iff (rst)
        $past(load) |-> (regs.vbr == 32'h0 && regs.imask == 4'hF && !regs.bo && !regs.cs
                         && regs.fpscr == 32'h0004_0001)) else $error("bad init values");  // R6
    AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (rst)
        !$past(load) |-> $stable(regs)) else $error("registers changed without load");  // R5
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int unsigned       ADDR_W      = 32,
    parameter int unsigned       QUAL_CYCLES = 20,
    parameter int unsigned       SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] VEC_BASE    = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_rst_n,
    input  logic              wdt_ovf,
    input  logic              dbg_mreset,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              run_en,
    output logic              reset_kind,
    output logic              periph_rst,
    output logic              bn_clr,
    output logic              arch_load,
    output logic [31:0]       pc_value,
    output logic [31:0]       sp_value,
    output logic [31:0]       vbr_value,
    output logic [3:0]        sr_imask,
    output logic              sr_bo,
    output logic              sr_cs,
    output logic [31:0]       fpscr_value
);
    logic              pin_high, qual_hit;
    logic              fetch_start, fetch_abort, fetch_done;
    logic [ADDR_W-1:0] fetch_addr;
    logic [WORD_W-1:0] fetch_data, pc_word, sp_word;
    rst_kind_e         kind;
    arch_init_t        regs;

    rstseq_qualifier #(
        .QUAL_CYCLES (QUAL_CYCLES),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_qual (
        .clk       (clk),
        .rst       (rst),
        .ext_rst_n (ext_rst_n),
        .pin_high  (pin_high),
        .qual_hit  (qual_hit)
    );

    rstseq_ctrl #(
        .ADDR_W   (ADDR_W),
        .VEC_BASE (VEC_BASE)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .qual_hit    (qual_hit),
        .pin_high    (pin_high),
        .manual_req  (wdt_ovf | dbg_mreset),
        .fetch_done  (fetch_done),
        .fetch_data  (fetch_data),
        .fetch_start (fetch_start),
        .fetch_addr  (fetch_addr),
        .fetch_abort (fetch_abort),
        .pc_word     (pc_word),
        .sp_word     (sp_word),
        .arch_load   (arch_load),
        .run_en      (run_en),
        .kind        (kind),
        .periph_rst  (periph_rst),
        .bn_clr      (bn_clr)
    );

    rstseq_vec_fetch #(
        .ADDR_W (ADDR_W)
    ) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .start      (fetch_start),
        .start_addr (fetch_addr),
        .abort      (fetch_abort),
        .req_valid  (mem_req_valid),
        .req_addr   (mem_req_addr),
        .req_ready  (mem_req_ready),
        .rsp_valid  (mem_rsp_valid),
        .rsp_data   (mem_rsp_data),
        .done       (fetch_done),
        .data       (fetch_data)
    );

    rstseq_arch_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .load    (arch_load),
        .pc_word (pc_word),
        .sp_word (sp_word),
        .regs    (regs)
    );

    assign reset_kind  = (kind == KIND_MANUAL);
    assign pc_value    = regs.pc;
    assign sp_value    = regs.sp;
    assign vbr_value   = regs.vbr;
    assign sr_imask    = regs.imask;
    assign sr_bo       = regs.bo;
    assign sr_cs       = regs.cs;
    assign fpscr_value = regs.fpscr;
endmodule

// File: tb/rstseq_top_tb_top.sv
`timescale 1ns/1ps
module rstseq_top_tb_top;
    localparam time CLK_P = 4ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_rst_n = 1'b1;
    logic        wdt_ovf = 1'b0, dbg_mreset = 1'b0;
    logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [31:0] mem_req_addr, mem_rsp_data;
    logic        run_en, reset_kind, periph_rst, bn_clr, arch_load;
    logic [31:0] pc_value, sp_value, vbr_value, fpscr_value;
    logic [3:0]  sr_imask;
    logic        sr_bo, sr_cs;

    always #(CLK_P/2) clk = ~clk;

    rstseq_top dut_i (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .wdt_ovf(wdt_ovf), .dbg_mreset(dbg_mreset),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .run_en(run_en),
        .reset_kind(reset_kind), .periph_rst(periph_rst), .bn_clr(bn_clr), .arch_load(arch_load),
        .pc_value(pc_value), .sp_value(sp_value), .vbr_value(vbr_value), .sr_imask(sr_imask),
        .sr_bo(sr_bo), .sr_cs(sr_cs), .fpscr_value(fpscr_value)
    );

    int n_tests = 0, n_fail = 0;
    int ready_dly = 2, rsp_dly = 1;
    logic [31:0] vec_pc = 32'h0, vec_sp = 32'h0;
    logic [31:0] addr_log [0:63];
    int n_acc = 0, n_load = 0, n_bn = 0, n_per = 0, n_order_err = 0;
    logic prev_run = 1'b0, prev_load = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // read responder: programmable ready and response delays
    initial begin
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_valid) begin
                repeat (ready_dly) @(negedge clk);
                if (n_acc < 64) addr_log[n_acc] = mem_req_addr;
                n_acc++;
                mem_req_ready = 1'b1;
                mem_rsp_data  = (mem_req_addr == 32'h4) ? vec_sp : vec_pc;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (rsp_dly) @(negedge clk);
                mem_rsp_valid = 1'b1;
            end
        end
    end

    // strobe monitor, sampled on falling edges
    initial begin
        forever begin
            @(negedge clk);
            if (arch_load)  n_load++;
            if (bn_clr)     n_bn++;
            if (periph_rst) n_per++;
            if (run_en && !prev_run && !prev_load) n_order_err++;
            prev_run  = run_en;
            prev_load = arch_load;
        end
    end

    task automatic hold_pin_low(input int cycles);
        @(negedge clk); ext_rst_n = 1'b0;
        repeat (cycles) @(negedge clk);
        ext_rst_n = 1'b1;
    endtask

    task automatic wait_run(input string tag);
        int k;
        for (k = 0; k < 500; k++) begin
            if (run_en) break;
            @(negedge clk);
        end
        check(run_en === 1'b1, {tag, " run_en timeout"}, {31'b0, run_en}, 32'h1);
    endtask

    task automatic check_loaded(input string tag);
        check(pc_value == vec_pc, {tag, " R5 pc"}, pc_value, vec_pc);
        check(sp_value == vec_sp, {tag, " R5 sp"}, sp_value, vec_sp);
        check(vbr_value == 32'h0, {tag, " R6 vbr"}, vbr_value, 32'h0);
        check(sr_imask == 4'hF, {tag, " R6 imask"}, {28'b0, sr_imask}, 32'hF);
        check({sr_bo, sr_cs} == 2'b00, {tag, " R6 bo/cs"}, {30'b0, sr_bo, sr_cs}, 32'h0);
        check(fpscr_value == 32'h0004_0001, {tag, " R6 fpscr"}, fpscr_value, 32'h0004_0001);
        check(n_order_err == 0, {tag, " R7 run before load"}, n_order_err, 32'h0);
    endtask

    task automatic t_reset_state;
        rst = 1'b1;
        repeat (5) @(negedge clk);
        check(!run_en && !mem_req_valid && !periph_rst && !arch_load && !bn_clr && !reset_kind,
              "R1 outputs in reset", {26'b0, run_en, mem_req_valid, periph_rst, arch_load, bn_clr, reset_kind}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(!run_en && !mem_req_valid && !periph_rst && !reset_kind, "R1 outputs after reset",
              {28'b0, run_en, mem_req_valid, periph_rst, reset_kind}, 32'h0);
    endtask

    task automatic t_idle_manual_ignored;
        int a0 = n_acc;
        @(negedge clk); wdt_ovf = 1'b1; @(negedge clk); wdt_ovf = 1'b0; dbg_mreset = 1'b1;
        @(negedge clk); dbg_mreset = 1'b0;
        repeat (30) @(negedge clk);
        check(n_acc == a0 && !run_en, "R10 manual request in idle", n_acc - a0, 32'h0);
    endtask

    task automatic t_short_pulse_idle;
        int a0 = n_acc;
        hold_pin_low(19);
        repeat (40) @(negedge clk);
        check(n_acc == a0, "R2 19-cycle pulse issued reads", n_acc - a0, 32'h0);
        check(!run_en, "R2 19-cycle pulse started run", {31'b0, run_en}, 32'h0);
    endtask

    task automatic t_power_on;
        int a0 = n_acc, p0 = n_per, b0 = n_bn, l0 = n_load;
        ready_dly = 3; rsp_dly = 2; vec_pc = 32'h0000_1000; vec_sp = 32'hFFFF_F000;
        @(negedge clk); ext_rst_n = 1'b0;
        repeat (30) @(negedge clk);
        check(!mem_req_valid && n_acc == a0, "R3 read while pin low", n_acc - a0, 32'h0);
        check(!run_en, "R3 run while pin low", {31'b0, run_en}, 32'h0);
        ext_rst_n = 1'b1;
        wait_run("R4 power-on");
        check(n_acc - a0 == 2, "R4 read count", n_acc - a0, 32'h2);
        check(addr_log[a0] == 32'h0, "R4 first address", addr_log[a0], 32'h0);
        check(addr_log[a0+1] == 32'h4, "R4 second address", addr_log[a0+1], 32'h4);
        check_loaded("power-on");
        check(n_load - l0 == 1, "R7 load pulses", n_load - l0, 32'h1);
        check(!reset_kind, "R8 kind", {31'b0, reset_kind}, 32'h0);
        check(n_per - p0 == 1, "R8 periph pulses", n_per - p0, 32'h1);
        check(n_bn - b0 == 1, "R8 bank clear pulses", n_bn - b0, 32'h1);
    endtask

    task automatic t_short_in_run;
        int a0 = n_acc, drops = 0;
        @(negedge clk); ext_rst_n = 1'b0;
        for (int k = 0; k < 19; k++) begin
            @(negedge clk);
            if (!run_en) drops++;
        end
        ext_rst_n = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (!run_en) drops++;
        end
        check(drops == 0, "R2 short pulse dropped run", drops, 32'h0);
        check(n_acc == a0, "R2 short pulse issued reads", n_acc - a0, 32'h0);
    endtask

    task automatic t_exact_qual_in_run;
        int p0 = n_per, seen_low = 0;
        vec_pc = 32'h0000_2000;
        hold_pin_low(20);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (!run_en) seen_low++;
        end
        check(seen_low > 0, "R11 20-cycle pulse in run", seen_low, 32'h1);
        wait_run("R2 20-cycle rerun");
        check(pc_value == 32'h0000_2000, "R2 rerun pc", pc_value, 32'h0000_2000);
        check(!reset_kind && n_per - p0 == 1, "R8 rerun kind/periph", {31'b0, reset_kind}, 32'h0);
    endtask

    task automatic t_manual(input bit use_dbg, input logic [31:0] pcw, input logic [31:0] spw);
        int a0 = n_acc, p0 = n_per, b0 = n_bn, l0 = n_load;
        vec_pc = pcw; vec_sp = spw;
        @(negedge clk);
        if (use_dbg) dbg_mreset = 1'b1; else wdt_ovf = 1'b1;
        @(negedge clk);
        dbg_mreset = 1'b0; wdt_ovf = 1'b0;
        check(!run_en, "R9 run after manual pulse", {31'b0, run_en}, 32'h0);
        wait_run("R9 manual");
        check(reset_kind, "R9 kind", {31'b0, reset_kind}, 32'h1);
        check(n_per == p0 && n_bn == b0, "R9 peripheral/bank strobes", n_per - p0 + n_bn - b0, 32'h0);
        check(n_load - l0 == 1, "R9 load pulses", n_load - l0, 32'h1);
        check(addr_log[a0] == 32'h0 && addr_log[a0+1] == 32'h4, "R9 read order", addr_log[a0+1], 32'h4);
        check_loaded("R9 manual");
    endtask

    task automatic t_manual_during_qualify;
        int p0 = n_per;
        vec_pc = 32'h0000_4000;
        @(negedge clk); ext_rst_n = 1'b0;
        repeat (25) @(negedge clk);
        dbg_mreset = 1'b1; @(negedge clk); dbg_mreset = 1'b0;
        repeat (3) @(negedge clk);
        ext_rst_n = 1'b1;
        wait_run("R10 qualify");
        check(!reset_kind, "R10 kind after manual in qualify", {31'b0, reset_kind}, 32'h0);
        check(n_per - p0 == 1, "R10 periph pulses", n_per - p0, 32'h1);
    endtask

    task automatic t_qual_during_fetch;
        int b0 = n_bn, l0 = n_load;
        ready_dly = 30; vec_pc = 32'h0000_5000; vec_sp = 32'h0000_7FF0;
        @(negedge clk); wdt_ovf = 1'b1; @(negedge clk); wdt_ovf = 1'b0;
        repeat (3) @(negedge clk);
        check(mem_req_valid, "R11 read stalled", {31'b0, mem_req_valid}, 32'h1);
        ext_rst_n = 1'b0;
        repeat (25) @(negedge clk);
        check(!run_en && !mem_req_valid, "R11 stalled read withdrawn", {30'b0, run_en, mem_req_valid}, 32'h0);
        ready_dly = 1;
        ext_rst_n = 1'b1;
        wait_run("R11 restart");
        check(!reset_kind, "R11 kind after restart", {31'b0, reset_kind}, 32'h0);
        check(n_bn - b0 == 1 && n_load - l0 == 1, "R11 single load", n_load - l0, 32'h1);
        check_loaded("R11 restart");
    endtask

    initial begin
        #(CLK_P * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_idle_manual_ignored();
        t_short_pulse_idle();
        t_power_on();
        t_short_in_run();
        t_exact_qual_in_run();
        t_manual(1'b0, 32'h0000_3000, 32'h0000_3FF0);
        ready_dly = 0; rsp_dly = 0;
        t_manual(1'b1, 32'h0000_3100, 32'h0000_8000);
        ready_dly = 2; rsp_dly = 1;
        t_manual_during_qualify();
        t_qual_during_fetch();
        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule